// File: doc/BRIEF.md
# Status Register Write Guard

This block owns the status register of a serial memory and decides, for every decoded status-write command, whether the new value may be taken. It tracks a sticky write-disable bit, a block-protect field, a write-enable latch and a busy copy. A separate protect input pin works together with the sticky bit to lock the register. When the bit is set and the pin is low, the block is in hardware-protected mode. In that mode the block-protect field is frozen, so the memory region it covers cannot be changed. The mode can be entered by setting the bit and pulling the pin low in either order. The only way out is to raise the pin.

The surrounding serial front end decodes opcodes into one-cycle strobes: enable, disable and status write. The status-write strobe carries a data byte. For each status-write attempt the block answers with a one-cycle accept or reject pulse. The pulse comes out in the same cycle as the register update. A level output shows hardware-protected mode.

Top module: `stat_reg_guard`

## Requirements
- R1: Reset clears every status bit, both verdict pulses and the protected-mode flag.
- R2: An enable strobe sets status bit 1 (write-enable latch) at the next clock edge. A disable strobe clears it at the next clock edge.
- R3: A status write is accepted when the latch is 1 and the register is not locked. On acceptance, bit 7 and bits 4:2 take the data byte's bits 7 and 4:2, `wrsr_accept` pulses for one cycle, and the latch clears.
- R4: A status write with the latch at 0 gives a one-cycle `wrsr_reject` pulse and leaves bits 7:2 unchanged.
- R5: With bit 7 at 1 and `wp_n` low, a status write is rejected even when the latch is 1. Bits 7:2 stay as they were and the latch stays set.
- R6: `hw_protected` is high exactly while bit 7 is 1 and `wp_n` is low. It is reached both by setting bit 7 while the pin is low and by lowering the pin after bit 7 is set.
- R7: Raising `wp_n` ends protected mode in the same cycle. A status write accepted while the pin is high may change or clear bit 7.
- R8: Status bit 0 shows `busy_in` one cycle late. A status write that arrives while bit 0 reads 1 gives no pulse and changes nothing. Enable strobes still act while bit 0 reads 1.
- R9: Data bits 6, 5, 1 and 0 of a status write are ignored. Status bits 6 and 5 always read 0.
- R10: When enable and disable strobes arrive in the same cycle, the disable wins and the latch reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren | input | 1 | Decoded write-enable strobe |
| cmd_wrdi | input | 1 | Decoded write-disable strobe |
| cmd_wrsr | input | 1 | Decoded status-write strobe |
| wrsr_data | input | REG_W | Data byte carried by the status write |
| wp_n | input | 1 | Protect pin; low enables hardware locking |
| busy_in | input | 1 | Busy flag from the program/erase engine |
| status | output | REG_W | Status register value |
| wrsr_accept | output | 1 | One-cycle pulse: status write taken |
| wrsr_reject | output | 1 | One-cycle pulse: status write refused |
| hw_protected | output | 1 | Hardware-protected mode active |

## Verification
The bench builds the block with its defaults: an 8-bit register, a 3-bit protect field and no synchronizer on the protect pin. With the pin unsynchronized, the protected-mode flag follows the pin in the same cycle. This lets one vector table check the flag every cycle, next to the register value and both pulses. It covers both orders of entering protected mode, leaving it, and busy rising in the same cycle as a status write.

// File: rtl/stat_guard_pkg.sv
package stat_guard_pkg;

   // Fixed low-order field positions of the status register
   localparam int BUSY_POS = 0;
   localparam int WEL_POS  = 1;
   localparam int BP_LSB   = 2;

   // Outcome of one status-write strobe
   typedef enum logic [1:0] {
      WR_NONE   = 2'd0,
      WR_ACCEPT = 2'd1,
      WR_LOCKED = 2'd2,
      WR_NO_WEL = 2'd3
   } wr_verdict_t;

   function automatic logic is_reject(input wr_verdict_t v);
      return (v == WR_LOCKED) || (v == WR_NO_WEL);
   endfunction

endpackage

// File: rtl/sg_pin_cond.sv
module sg_pin_cond #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic pin_out
);

   if (STAGES < 0) begin : g_bad_stages
      $error("sg_pin_cond: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign pin_out = pin_in;
   end else begin : g_sync
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sh_q <= '0;
         end else begin
            sh_q[0] <= pin_in;
            for (int i = 1; i < STAGES; i++) begin
               sh_q[i] <= sh_q[i-1];
            end
         end
      end
      assign pin_out = sh_q[STAGES-1];
   end

endmodule

// File: rtl/sg_wr_judge.sv
module sg_wr_judge
   import stat_guard_pkg::*;
(
   input  logic        wrsr,
   input  logic        busy,
   input  logic        wd,
   input  logic        wel,
   input  logic        pin,
   output wr_verdict_t verdict
);

   always_comb begin
      verdict = WR_NONE;
      if (wrsr && !busy) begin
         if (wd && !pin) begin
            verdict = WR_LOCKED;
         end else if (!wel) begin
            verdict = WR_NO_WEL;
         end else begin
            verdict = WR_ACCEPT;
         end
      end
   end

endmodule

// File: rtl/sg_stat_regs.sv
module sg_stat_regs
   import stat_guard_pkg::*;
#(
   parameter int BP_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  wr_verdict_t     verdict,
   input  logic            new_wd,
   input  logic [BP_W-1:0] new_bp,
   input  logic            wren,
   input  logic            wrdi,
   input  logic            busy_in,
   output logic            wd_q,
   output logic [BP_W-1:0] bp_q,
   output logic            wel_q,
   output logic            busy_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wd_q   <= 1'b0;
         bp_q   <= '0;
         wel_q  <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         busy_q <= busy_in;
         if (verdict == WR_ACCEPT) begin
            wd_q <= new_wd;
            bp_q <= new_bp;
         end
         if (verdict == WR_ACCEPT) begin
            wel_q <= 1'b0;
         end else if (wrdi) begin
            wel_q <= 1'b0;
         end else if (wren) begin
            wel_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/stat_reg_guard.sv
module stat_reg_guard
   import stat_guard_pkg::*;
#(
   parameter int REG_W    = 8,
   parameter int BP_W     = 3,
   parameter int PIN_SYNC = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wren,
   input  logic             cmd_wrdi,
   input  logic             cmd_wrsr,
   input  logic [REG_W-1:0] wrsr_data,
   input  logic             wp_n,
   input  logic             busy_in,
   output logic [REG_W-1:0] status,
   output logic             wrsr_accept,
   output logic             wrsr_reject,
   output logic             hw_protected
);

   localparam int WD_POS = REG_W - 1;
   localparam int BP_MSB = BP_LSB + BP_W - 1;
   localparam logic [REG_W-1:0] USED_MASK =
      (REG_W'(1) << WD_POS) | (REG_W'((1 << BP_W) - 1) << BP_LSB);

   if (BP_W < 1) begin : g_bad_bpw
      $error("stat_reg_guard: BP_W must be at least 1");
   end
   if (BP_MSB >= WD_POS) begin : g_bad_layout
      $error("stat_reg_guard: protect field overlaps the write-disable bit");
   end

   logic            pin_eff;
   wr_verdict_t     verdict;
   logic            wd_q;
   logic [BP_W-1:0] bp_q;
   logic            wel_q;
   logic            busy_q;
   logic            acc_q;
   logic            rej_q;
   logic            unused_data_bits;

   assign unused_data_bits = ^(wrsr_data & ~USED_MASK);

   sg_pin_cond #(.STAGES(PIN_SYNC)) u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_in  (wp_n),
      .pin_out (pin_eff)
   );

   sg_wr_judge u_judge (
      .wrsr    (cmd_wrsr),
      .busy    (busy_q),
      .wd      (wd_q),
      .wel     (wel_q),
      .pin     (pin_eff),
      .verdict (verdict)
   );

   sg_stat_regs #(.BP_W(BP_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .verdict (verdict),
      .new_wd  (wrsr_data[WD_POS]),
      .new_bp  (wrsr_data[BP_MSB:BP_LSB]),
      .wren    (cmd_wren),
      .wrdi    (cmd_wrdi),
      .busy_in (busy_in),
      .wd_q    (wd_q),
      .bp_q    (bp_q),
      .wel_q   (wel_q),
      .busy_q  (busy_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= 1'b0;
         rej_q <= 1'b0;
      end else begin
         acc_q <= (verdict == WR_ACCEPT);
         rej_q <= is_reject(verdict);
      end
   end

   always_comb begin
      status                 = '0;
      status[WD_POS]         = wd_q;
      status[BP_MSB:BP_LSB]  = bp_q;
      status[WEL_POS]        = wel_q;
      status[BUSY_POS]       = busy_q;
   end

   assign wrsr_accept  = acc_q;
   assign wrsr_reject  = rej_q;
   assign hw_protected = wd_q & ~pin_eff;

endmodule

// File: rtl/stat_reg_guard_chk.sv
module stat_reg_guard_chk
   import stat_guard_pkg::*;
#(
   parameter int REG_W = 8,
   parameter int BP_W  = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_wren,
   input logic             cmd_wrdi,
   input logic             cmd_wrsr,
   input logic [REG_W-1:0] wrsr_data,
   input logic [REG_W-1:0] status,
   input logic             wrsr_accept,
   input logic             wrsr_reject,
   input logic             hw_protected
);

   localparam int WD_POS = REG_W - 1;
   localparam int BP_MSB = BP_LSB + BP_W - 1;

   // R3: accepted write loads the data fields
   a_r3_accept_loads: assert property (@(posedge clk) disable iff (!rst_n)
      wrsr_accept |-> (status[WD_POS] == $past(wrsr_data[WD_POS])) &&
                      (status[BP_MSB:BP_LSB] == $past(wrsr_data[BP_MSB:BP_LSB])));

   // R3: accepted write clears the latch
   a_r3_accept_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
      wrsr_accept |-> !status[WEL_POS]);

   // R3: a verdict pulse only follows a status-write strobe
   a_r3_pulse_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
      (wrsr_accept || wrsr_reject) |-> $past(cmd_wrsr));

   // R4: rejected write keeps the register fields
   a_r4_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
      wrsr_reject |-> status[REG_W-1:BP_LSB] == $past(status[REG_W-1:BP_LSB]));

   // R4: never both verdicts at once
   a_r4_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
      !(wrsr_accept && wrsr_reject));

   // R5: protected mode refuses a status write
   a_r5_hpm_rejects: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_wrsr && hw_protected && !status[BUSY_POS]) |-> wrsr_reject);

   // R5: a locked refusal keeps the latch
   a_r5_locked_keeps_wel: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_wrsr && hw_protected && !status[BUSY_POS] && !cmd_wren && !cmd_wrdi)
      |-> status[WEL_POS] == $past(status[WEL_POS]));

   // R6: protected mode needs the write-disable bit
   a_r6_hpm_needs_wd: assert property (@(posedge clk) disable iff (!rst_n)
      hw_protected |-> status[WD_POS]);

   // R8: busy gates status writes
   a_r8_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_wrsr && status[BUSY_POS]) |-> !wrsr_accept && !wrsr_reject);

   // R8: fields hold while busy is shown
   a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      $past(status[BUSY_POS]) |-> status[REG_W-1:BP_LSB] == $past(status[REG_W-1:BP_LSB]));

   // R2: enable strobe alone sets the latch
   a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_wren && !cmd_wrdi && !cmd_wrsr) |-> status[WEL_POS]);

   // R10: disable strobe always leaves the latch clear
   a_r10_wrdi_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cmd_wrdi) |-> !status[WEL_POS]);

endmodule

bind stat_reg_guard stat_reg_guard_chk #(.REG_W(REG_W), .BP_W(BP_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cmd_wren     (cmd_wren),
   .cmd_wrdi     (cmd_wrdi),
   .cmd_wrsr     (cmd_wrsr),
   .wrsr_data    (wrsr_data),
   .status       (status),
   .wrsr_accept  (wrsr_accept),
   .wrsr_reject  (wrsr_reject),
   .hw_protected (hw_protected)
);

// File: tb/sim_stat_reg_guard.sv
`timescale 1ns/1ps
module sim_stat_reg_guard;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wren = 1'b0;
   logic       cmd_wrdi = 1'b0;
   logic       cmd_wrsr = 1'b0;
   logic [7:0] wrsr_data = 8'h00;
   logic       wp_n = 1'b1;
   logic       busy_in = 1'b0;
   logic [7:0] status;
   logic       wrsr_accept;
   logic       wrsr_reject;
   logic       hw_protected;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   stat_reg_guard u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_wren     (cmd_wren),
      .cmd_wrdi     (cmd_wrdi),
      .cmd_wrsr     (cmd_wrsr),
      .wrsr_data    (wrsr_data),
      .wp_n         (wp_n),
      .busy_in      (busy_in),
      .status       (status),
      .wrsr_accept  (wrsr_accept),
      .wrsr_reject  (wrsr_reject),
      .hw_protected (hw_protected)
   );

   typedef struct packed {
      logic       wren;
      logic       wrdi;
      logic       wrsr;
      logic [7:0] data;
      logic       wp;
      logic       busy;
      logic [7:0] st;
      logic       acc;
      logic       rej;
      logic       hpm;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 25;
   localparam vec_t VEC [NV] = '{
      '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,4'd1},  // R1 idle
      '{1'b0,1'b0,1'b1,8'hFF,1'b1,1'b0,8'h00,1'b0,1'b1,1'b0,4'd4},  // R4 no latch
      '{1'b1,1'b0,1'b0,8'h00,1'b1,1'b0,8'h02,1'b0,1'b0,1'b0,4'd2},  // R2 set
      '{1'b0,1'b1,1'b0,8'h00,1'b1,1'b0,8'h00,1'b0,1'b0,1'b0,4'd2},  // R2 clear
      '{1'b1,1'b0,1'b0,8'h00,1'b1,1'b0,8'h02,1'b0,1'b0,1'b0,4'd2},
      '{1'b0,1'b0,1'b1,8'h9C,1'b1,1'b0,8'h9C,1'b1,1'b0,1'b0,4'd3},  // R3 load
      '{1'b1,1'b0,1'b0,8'h00,1'b1,1'b0,8'h9E,1'b0,1'b0,1'b0,4'd2},
      '{1'b0,1'b0,1'b1,8'h80,1'b1,1'b0,8'h80,1'b1,1'b0,1'b0,4'd7},  // R7 pin high allows
      '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,8'h80,1'b0,1'b0,1'b1,4'd6},  // R6 pin low after bit
      '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,8'h82,1'b0,1'b0,1'b1,4'd2},
      '{1'b0,1'b0,1'b1,8'h00,1'b0,1'b0,8'h82,1'b0,1'b1,1'b1,4'd5},  // R5 locked
      '{1'b0,1'b0,1'b1,8'h1C,1'b0,1'b0,8'h82,1'b0,1'b1,1'b1,4'd5},  // R5 locked
      '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,8'h82,1'b0,1'b0,1'b0,4'd7},  // R7 exit
      '{1'b0,1'b0,1'b1,8'h7F,1'b1,1'b0,8'h1C,1'b1,1'b0,1'b0,4'd9},  // R9 spare bits
      '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b0,8'h1C,1'b0,1'b0,1'b0,4'd6},  // R6 no bit
      '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b0,8'h1E,1'b0,1'b0,1'b0,4'd2},
      '{1'b0,1'b0,1'b1,8'h80,1'b0,1'b0,8'h80,1'b1,1'b0,1'b1,4'd6},  // R6 bit set while pin low
      '{1'b0,1'b0,1'b0,8'h00,1'b0,1'b1,8'h81,1'b0,1'b0,1'b1,4'd8},  // R8 busy shown
      '{1'b1,1'b0,1'b0,8'h00,1'b0,1'b1,8'h83,1'b0,1'b0,1'b1,4'd8},  // R8 enable acts
      '{1'b0,1'b0,1'b1,8'h00,1'b1,1'b1,8'h83,1'b0,1'b0,1'b0,4'd8},  // R8 ignored
      '{1'b0,1'b0,1'b0,8'h00,1'b1,1'b0,8'h82,1'b0,1'b0,1'b0,4'd8},
      '{1'b1,1'b1,1'b0,8'h00,1'b1,1'b0,8'h80,1'b0,1'b0,1'b0,4'd10}, // R10 both strobes
      '{1'b0,1'b0,1'b1,8'h00,1'b1,1'b0,8'h80,1'b0,1'b1,1'b0,4'd4},  // R4 no latch
      '{1'b1,1'b0,1'b0,8'h00,1'b1,1'b0,8'h82,1'b0,1'b0,1'b0,4'd2},
      '{1'b0,1'b0,1'b1,8'h00,1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,4'd7}   // R7 clear bit
   };

   task automatic check(input int req, input logic [7:0] st, input logic acc,
                        input logic rej, input logic hpm);
      checks++;
      if (status !== st || wrsr_accept !== acc || wrsr_reject !== rej ||
          hw_protected !== hpm) begin
         fails++;
         $display("FAIL R%0d: got st=%h acc=%b rej=%b hpm=%b, expected st=%h acc=%b rej=%b hpm=%b",
                  req, status, wrsr_accept, wrsr_reject, hw_protected, st, acc, rej, hpm);
      end
   endtask

   task automatic drive(input logic wr, input logic wd, input logic ws,
                        input logic [7:0] d, input logic wp, input logic bz);
      @(negedge clk);
      cmd_wren  = wr;
      cmd_wrdi  = wd;
      cmd_wrsr  = ws;
      wrsr_data = d;
      wp_n      = wp;
      busy_in   = bz;
      @(posedge clk);
      #2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      #2;
      check(1, 8'h00, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #2;
      check(1, 8'h00, 1'b0, 1'b0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].wren, VEC[i].wrdi, VEC[i].wrsr, VEC[i].data, VEC[i].wp, VEC[i].busy);
         check(int'(VEC[i].req), VEC[i].st, VEC[i].acc, VEC[i].rej, VEC[i].hpm);
      end

      // R8: busy rising with the write itself does not block it
      drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
      check(8, 8'h02, 1'b0, 1'b0, 1'b0);
      drive(1'b0, 1'b0, 1'b1, 8'h80, 1'b1, 1'b1);
      check(8, 8'h81, 1'b1, 1'b0, 1'b0);
      drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
      check(6, 8'h80, 1'b0, 1'b0, 1'b1);

      // R1: reset in mid-run clears a locked register
      drive(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
      check(2, 8'h82, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
      cmd_wren = 1'b0;
      rst_n = 1'b0;
      @(posedge clk);
      #2;
      check(1, 8'h00, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 1'b1, 8'h9C, 1'b0, 1'b0);
      check(4, 8'h00, 1'b0, 1'b1, 1'b0);

      finish_run();
   end

endmodule